// File: doc/BRIEF.md
# Vertex output semantic router

This block turns the raw output of a vertex program into a fixed vertex record. It accepts up to seven attributes, each holding four 24-bit floats. For each attribute there is a 32-bit map word that gives a semantic slot number for every component. The block places every active component into the slot named for it, out of 24 slots. Those slots carry position, rotation quaternion, color, texture coordinates and view vector.

After routing, the four color slots are conditioned: the sign is removed and any magnitude of one or more becomes exactly one. A single-cycle start pulse captures the inputs. The finished record, a done flag and an error flag appear on the next cycle and hold until the next start.

The float format has a sign in bit 23, seven exponent bits with bias 63 and sixteen mantissa bits. In this format 1.0 is 0x3F0000.

Top module: `vtx_sem_router`

## Requirements
- R1: While reset is high and in the cycle after it, `done` and `id_error` are 0 and every bit of `vertex_out` is 0.
- R2: `done` is 1 exactly in the cycle after a cycle with `start` high. The record and error flag captured at that start hold unchanged, whatever the inputs do, until the next start.
- R3: Only attributes with an index below `attr_count` (0 to 7) are routed. Higher-numbered attributes write nothing and raise no error.
- R4: Component n (x=0, y=1, z=2, w=3) of attribute a takes its slot ID from bits [8n+4:8n] of map word a. Map word a occupies `map_flat[32a+31:32a]`. Bits 8n+7 to 8n+5 are ignored.
- R5: An ID from 0 to 23 writes the component into slot ID, which is `vertex_out[24*ID+23:24*ID]`. A slot that no active component targets reads 0.
- R6: ID 31 is a discard code. It writes no slot and raises no error.
- R7: IDs 24 to 30 on an active component write no slot and set `id_error` for that result. The same IDs on an inactive attribute do not set it.
- R8: When several active components target one slot, the higher attribute index wins. Within one attribute, the later component in x, y, z, w order wins.
- R9: Slots 8 to 11 (color) have bit 23 cleared in the result. All other slots pass their value through unchanged, sign included.
- R10: A color value whose magnitude (bits 22:0) is 0x3F0000 or above becomes exactly 0x3F0000. A smaller magnitude is left as is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture pulse for one record |
| attr_count | input | 3 | Number of active attributes |
| map_flat | input | 224 | Seven 32-bit map words, attribute 0 in the low bits |
| attr_data | input | 672 | 28 components of 24 bits, index 4*attr+comp |
| done | output | 1 | Result valid, one cycle after start |
| id_error | output | 1 | An active component carried ID 24 to 30 |
| vertex_out | output | 576 | 24 slots of 24 bits, slot 0 in the low bits |

## Verification
The hardest case to reach is a slot that is claimed several times in one record. The final value then depends on priority across attributes, on priority within one attribute, and on whether the colliding attribute lies above `attr_count`. The priority test maps one slot from two attributes, and a second slot from two components of the same attribute. It then repeats the collision with the winning attribute made inactive, so the lower claimant must reappear. Reserved IDs are checked on an active and on an inactive attribute, so an error flag that ignores the count is exposed.

// File: rtl/vsr_pkg.sv
package vsr_pkg;

    localparam int VSR_FW         = 24;
    localparam int VSR_IDW        = 5;
    localparam int VSR_FIELD_STEP = 8;
    localparam int VSR_DROP_ID    = 31;
    localparam int VSR_COLOR_BASE = 8;
    localparam int VSR_COLOR_N    = 4;

    localparam logic [VSR_FW-1:0] VSR_ONE = 24'h3F0000;

    typedef logic [VSR_FW-1:0]  flt24_t;
    typedef logic [VSR_IDW-1:0] sem_id_t;

    // One routed component after decode.
    typedef struct packed {
        logic    active;
        sem_id_t id;
        flt24_t  val;
    } comp_route_t;

    // Absolute value followed by saturation at one.
    function automatic flt24_t abs_sat(input flt24_t f);
        flt24_t mag;
        mag = {1'b0, f[VSR_FW-2:0]};
        return (mag >= VSR_ONE) ? VSR_ONE : mag;
    endfunction

    // IDs beyond the record that are not the discard code.
    function automatic logic id_reserved(input sem_id_t id, input int slots);
        return (int'(id) >= slots) && (int'(id) != VSR_DROP_ID);
    endfunction

endpackage

// File: rtl/vsr_comp_decode.sv
module vsr_comp_decode
    import vsr_pkg::*;
#(
    parameter int N_ATTR = 7,
    parameter int N_COMP = 4,
    parameter int MAP_W  = 32,
    parameter int CNT_W  = 3,
    localparam int N_ROUTE = N_ATTR * N_COMP
) (
    input  logic [CNT_W-1:0]          attr_count,
    input  logic [N_ATTR*MAP_W-1:0]   map_flat,
    input  logic [N_ROUTE*VSR_FW-1:0] attr_data,
    output comp_route_t [N_ROUTE-1:0] routes
);

    for (genvar a = 0; a < N_ATTR; a++) begin : g_attr
        logic attr_live;
        assign attr_live = (int'(attr_count) > a);
        for (genvar c = 0; c < N_COMP; c++) begin : g_comp
            localparam int R = a * N_COMP + c;
            assign routes[R].active = attr_live;
            assign routes[R].id     = map_flat[a*MAP_W + c*VSR_FIELD_STEP +: VSR_IDW];
            assign routes[R].val    = attr_data[R*VSR_FW +: VSR_FW];
        end
    end

endmodule

// File: rtl/vsr_slot_mux.sv
module vsr_slot_mux
    import vsr_pkg::*;
#(
    parameter int N_ROUTE = 28,
    parameter int N_SLOT  = 24
) (
    input  comp_route_t [N_ROUTE-1:0] routes,
    output flt24_t      [N_SLOT-1:0]  slots
);

    for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
        localparam sem_id_t SID = sem_id_t'(s);
        always_comb begin
            slots[s] = '0;
            // Ascending route order: later claimants overwrite earlier ones.
            for (int r = 0; r < N_ROUTE; r++) begin
                if (routes[r].active && routes[r].id == SID) begin
                    slots[s] = routes[r].val;
                end
            end
        end
    end

endmodule

// File: rtl/vsr_color_cond.sv
module vsr_color_cond
    import vsr_pkg::*;
#(
    parameter int N_SLOT = 24
) (
    input  flt24_t [N_SLOT-1:0] raw_slots,
    output flt24_t [N_SLOT-1:0] cond_slots
);

    for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
        if (s >= VSR_COLOR_BASE && s < VSR_COLOR_BASE + VSR_COLOR_N) begin : g_color
            assign cond_slots[s] = abs_sat(raw_slots[s]);
        end else begin : g_pass
            assign cond_slots[s] = raw_slots[s];
        end
    end

endmodule

// File: rtl/vtx_sem_router.sv
module vtx_sem_router
    import vsr_pkg::*;
#(
    parameter int N_ATTR = 7,
    parameter int N_COMP = 4,
    parameter int N_SLOT = 24,
    parameter int MAP_W  = 32,
    parameter int CNT_W  = 3,
    localparam int N_ROUTE = N_ATTR * N_COMP
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic [CNT_W-1:0]          attr_count,
    input  logic [N_ATTR*MAP_W-1:0]   map_flat,
    input  logic [N_ROUTE*VSR_FW-1:0] attr_data,
    output logic                      done,
    output logic                      id_error,
    output logic [N_SLOT*VSR_FW-1:0]  vertex_out
);

    comp_route_t [N_ROUTE-1:0] routes;
    flt24_t      [N_SLOT-1:0]  raw_slots;
    flt24_t      [N_SLOT-1:0]  cond_slots;
    logic                      bad_id;

    vsr_comp_decode #(
        .N_ATTR(N_ATTR), .N_COMP(N_COMP), .MAP_W(MAP_W), .CNT_W(CNT_W)
    ) decode_i (
        .attr_count(attr_count),
        .map_flat  (map_flat),
        .attr_data (attr_data),
        .routes    (routes)
    );

    vsr_slot_mux #(
        .N_ROUTE(N_ROUTE), .N_SLOT(N_SLOT)
    ) mux_i (
        .routes(routes),
        .slots (raw_slots)
    );

    vsr_color_cond #(
        .N_SLOT(N_SLOT)
    ) color_i (
        .raw_slots (raw_slots),
        .cond_slots(cond_slots)
    );

    always_comb begin
        bad_id = 1'b0;
        for (int r = 0; r < N_ROUTE; r++) begin
            if (routes[r].active && id_reserved(routes[r].id, N_SLOT)) begin
                bad_id = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done       <= 1'b0;
            id_error   <= 1'b0;
            vertex_out <= '0;
        end else begin
            done <= start;
            if (start) begin
                id_error   <= bad_id;
                vertex_out <= cond_slots;
            end
        end
    end

endmodule

// File: rtl/vsr_checker.sv
module vsr_checker
    import vsr_pkg::*;
#(
    parameter int N_SLOT = 24
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     start,
    input logic                     done,
    input logic                     id_error,
    input logic [N_SLOT*VSR_FW-1:0] vertex_out
);

    // R2
    done_after_start_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> done);

    // R2
    no_spurious_done_chk: assert property (@(posedge clk) disable iff (rst)
        !start |=> !done);

    // R2
    record_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !start |=> ($stable(vertex_out) && $stable(id_error)));

    for (genvar k = 0; k < VSR_COLOR_N; k++) begin : g_col
        localparam int S = VSR_COLOR_BASE + k;
        // R9
        color_sign_clear_chk: assert property (@(posedge clk) disable iff (rst)
            done |-> !vertex_out[S*VSR_FW + VSR_FW-1]);
        // R10
        color_ceiling_chk: assert property (@(posedge clk) disable iff (rst)
            done |-> (vertex_out[S*VSR_FW +: VSR_FW] <= VSR_ONE));
    end

endmodule

bind vtx_sem_router vsr_checker #(.N_SLOT(N_SLOT)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .done      (done),
    .id_error  (id_error),
    .vertex_out(vertex_out)
);

// File: tb/vtx_sem_router_tb_top.sv
module vtx_sem_router_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NA = 7;
    localparam int NC = 4;
    localparam int NS = 24;
    localparam int FW = 24;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 start = 1'b0;
    logic [2:0]           attr_count = '0;
    logic [NA*32-1:0]     map_flat = '0;
    logic [NA*NC*FW-1:0]  attr_data = '0;
    logic                 done;
    logic                 id_error;
    logic [NS*FW-1:0]     vertex_out;

    int vectors = 0;
    int fails   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vtx_sem_router dut_i (
        .clk(clk), .rst(rst), .start(start), .attr_count(attr_count),
        .map_flat(map_flat), .attr_data(attr_data),
        .done(done), .id_error(id_error), .vertex_out(vertex_out)
    );

    function automatic logic [23:0] slot(input int s);
        return vertex_out[s*FW +: FW];
    endfunction

    task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clear_inputs();
        attr_count = '0;
        map_flat   = {(NA*4){8'd31}};
        attr_data  = '0;
    endtask

    task automatic set_map(input int a, input logic [7:0] x, input logic [7:0] y,
                           input logic [7:0] z, input logic [7:0] w);
        map_flat[a*32 +: 32] = {w, z, y, x};
    endtask

    task automatic set_dat(input int a, input int c, input logic [23:0] v);
        attr_data[(a*NC + c)*FW +: FW] = v;
    endtask

    // Pulse start for one cycle; returns at the falling edge after capture.
    task automatic fire();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 done", {23'd0, done}, 24'd0);
        chk("R1 err", {23'd0, id_error}, 24'd0);
        chk("R1 record", {23'd0, |vertex_out}, 24'd0);
    endtask

    task automatic t_basic();
        clear_inputs();
        attr_count = 3'd1;
        set_map(0, 8'd0, 8'd1, 8'd2, 8'd3);
        set_dat(0, 0, 24'h3F8000); set_dat(0, 1, 24'hBF0000);
        set_dat(0, 2, 24'h400000); set_dat(0, 3, 24'h3F0000);
        fire();
        chk("R2 done", {23'd0, done}, 24'd1);
        chk("R5 slot0", slot(0), 24'h3F8000);
        chk("R5 slot1", slot(1), 24'hBF0000);
        chk("R5 slot2", slot(2), 24'h400000);
        chk("R5 slot3", slot(3), 24'h3F0000);
        chk("R5 unwritten slot5", slot(5), 24'h0);
        chk("R6 no error", {23'd0, id_error}, 24'd0);
    endtask

    task automatic t_hold();
        set_dat(0, 0, 24'h123456);
        set_map(0, 8'd4, 8'd25, 8'd2, 8'd3);
        repeat (3) @(negedge clk);
        chk("R2 done low", {23'd0, done}, 24'd0);
        chk("R2 hold slot0", slot(0), 24'h3F8000);
        chk("R2 hold slot4", slot(4), 24'h0);
        chk("R2 hold err", {23'd0, id_error}, 24'd0);
    endtask

    task automatic t_count();
        clear_inputs();
        attr_count = 3'd2;
        set_map(1, 8'd12, 8'd31, 8'd31, 8'd31); set_dat(1, 0, 24'h111111);
        set_map(2, 8'd4, 8'd26, 8'd31, 8'd31);  set_dat(2, 0, 24'h222222);
        fire();
        chk("R3 active attr1", slot(12), 24'h111111);
        chk("R3 inactive attr2", slot(4), 24'h0);
        chk("R7 inactive reserved id", {23'd0, id_error}, 24'd0);
        clear_inputs();
        attr_count = 3'd7;
        set_map(6, 8'd23, 8'd31, 8'd31, 8'd31); set_dat(6, 0, 24'h0A0B0C);
        fire();
        chk("R3 count seven", slot(23), 24'h0A0B0C);
        attr_count = 3'd0;
        fire();
        chk("R3 count zero", slot(23), 24'h0);
    endtask

    task automatic t_field();
        clear_inputs();
        attr_count = 3'd1;
        set_map(0, 8'hE5, 8'h31, 8'hFF, 8'h5F);
        set_dat(0, 0, 24'h00AA00); set_dat(0, 1, 24'h00BB00);
        set_dat(0, 2, 24'h00CC00); set_dat(0, 3, 24'h00DD00);
        fire();
        chk("R4 x high bits ignored", slot(5), 24'h00AA00);
        chk("R4 y field", slot(17), 24'h00BB00);
        chk("R6 discard code via field", {23'd0, id_error}, 24'd0);
        chk("R7 id 31 from w field is discard", slot(0), 24'h0);
    endtask

    task automatic t_error();
        clear_inputs();
        attr_count = 3'd1;
        set_map(0, 8'd25, 8'd1, 8'd30, 8'd31);
        set_dat(0, 0, 24'h777777); set_dat(0, 1, 24'h010101);
        set_dat(0, 2, 24'h666666);
        fire();
        chk("R7 error set", {23'd0, id_error}, 24'd1);
        chk("R7 legal neighbour", slot(1), 24'h010101);
        chk("R7 slot1 only nonzero", {23'd0, |(vertex_out & ~({{(NS-2)*FW{1'b0}}, 24'hFFFFFF, 24'h0}))}, 24'd0);
    endtask

    task automatic t_prio();
        clear_inputs();
        attr_count = 3'd2;
        set_map(0, 8'd6, 8'd7, 8'd31, 8'd7);
        set_dat(0, 0, 24'hA00001); set_dat(0, 1, 24'hA00002); set_dat(0, 3, 24'hA00004);
        set_map(1, 8'd31, 8'd6, 8'd31, 8'd31);
        set_dat(1, 1, 24'hB00002);
        fire();
        chk("R8 higher attr wins", slot(6), 24'hB00002);
        chk("R8 later comp wins", slot(7), 24'hA00004);
        attr_count = 3'd1;
        fire();
        chk("R8 inactive claimant loses", slot(6), 24'hA00001);
    endtask

    task automatic t_color();
        clear_inputs();
        attr_count = 3'd2;
        set_map(0, 8'd8, 8'd9, 8'd10, 8'd11);
        set_dat(0, 0, 24'hBE8000); set_dat(0, 1, 24'h3F0000);
        set_dat(0, 2, 24'h400000); set_dat(0, 3, 24'hC12345);
        set_map(1, 8'd0, 8'd13, 8'd31, 8'd31);
        set_dat(1, 0, 24'h800001); set_dat(1, 1, 24'hBEFFFF);
        fire();
        chk("R9 negative color abs", slot(8), 24'h3E8000);
        chk("R10 exactly one", slot(9), 24'h3F0000);
        chk("R10 above one clamps", slot(10), 24'h3F0000);
        chk("R10 negative above one", slot(11), 24'h3F0000);
        chk("R9 non-color keeps sign", slot(0), 24'h800001);
        chk("R9 texcoord keeps sign", slot(13), 24'hBEFFFF);
        clear_inputs();
        attr_count = 3'd1;
        set_map(0, 8'd8, 8'd31, 8'd31, 8'd31);
        set_dat(0, 0, 24'hBEFFFF);
        fire();
        chk("R10 just below one", slot(8), 24'h3EFFFF);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        clear_inputs();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_hold();
        t_count();
        t_field();
        t_error();
        t_prio();
        t_color();
        @(negedge clk);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule